// File: doc/BRIEF.md
# Oversampled Anti-Aliased Wavetable Oscillator

This block plays one single-cycle waveform, stored in on-chip block RAM, and produces one output sample for every frame strobe at the audio frame rate. A 32-bit phase accumulator walks the table. The top address bits of the phase increment give the integer table step per output sample. While that step is small the table is read once per frame. Once the step exceeds a programmable threshold, the table would alias at the output rate. In that case the block takes sixteen equally spaced table points inside the output period, runs them through two identical cascaded biquad low-pass sections, and keeps only the last filtered value. That is, it decimates the oversampled stream back to one sample per frame.

In oversampled mode the decimated value is scaled by a gain picked by the octave of the step, which compensates for the different effective rates. Every result is then scaled by the gain input. All arithmetic goes through one shared signed multiplier, stepped by a small sequencer. The result arrives well inside one output period, and a one-cycle valid pulse marks it. A simple write-only register port loads the table, the filter coefficients, the mode threshold and the octave gains.

Top module: `aa_wavetable_osc`

## Requirements
- R1: After reset out_valid and out_sample are 0 and the phase is 0. The threshold resets to all ones, so every step plays in direct mode. The coefficients reset to b0 = 1.0 with the others 0, giving a passthrough filter. Every octave gain resets to 1.0. All gains and coefficients are signed Q2.14, so 1.0 = 16384.
- R2: A write with cfg_we high decodes cfg_addr[11:10] as the region. Region 0 writes table entry cfg_addr[9:0]. Region 1 writes coefficient cfg_addr[2:0], where 0 = b0, 1 = b1, 2 = b2, 3 = a1 and 4 = a2. Region 2 writes the threshold from cfg_wdata[9:0]. Region 3 writes octave gain cfg_addr[3:0], for indices 0..9.
- R3: With step = phase_inc[31:22] not above the threshold (direct mode), the result is sat(table[phase[31:22]] * gain >>> 14) and the phase advances by phase_inc. The phase changes only while a frame is being processed.
- R4: Oversampled mode is chosen for a frame exactly when the step is strictly greater than the threshold.
- R5: In oversampled mode, sixteen points are read at phase, phase+s, ..., phase+15s, where s = phase_inc >> 4. The phase then ends advanced by 16*s.
- R6: Each oversampled point x passes through section 1, giving m = sat((b0*x + b1*x1 + b2*x2 - a1*m1 - a2*m2) >>> 14). It then passes through section 2, with the same coefficients, giving y = sat((b0*m + b1*m1 + b2*m2 - a1*y1 - a2*y2) >>> 14). Here >>> is a floor shift and sat clamps to the signed 16-bit range. The last y of the frame is kept.
- R7: The filter history carries over between consecutive oversampled frames. It is cleared to zero at the start of any frame whose mode differs from the previous frame's mode. The mode before the first frame counts as direct.
- R8: In oversampled mode the kept value becomes sat(y * octave_gain[k] >>> 14), where k is the bit index of the highest set bit of the step. The gain input is then applied as in R3.
- R9: out_valid is high for exactly one cycle per accepted frame, within 200 cycles of the strobe. out_sample holds its value between pulses.
- R10: A frame strobe that arrives while a frame is still in progress is ignored. It produces no extra result and no extra phase advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_strobe | input | 1 | Requests one output sample |
| phase_inc | input | 32 | Phase increment per output sample |
| gain | input | 16 | Output gain, signed Q2.14 |
| cfg_we | input | 1 | Register port write enable |
| cfg_addr | input | 12 | Register port address (region in bits 11:10) |
| cfg_wdata | input | 16 | Register port write data |
| out_sample | output | 16 | Signed output sample |
| out_valid | output | 1 | One-cycle pulse marking a new out_sample |

## Verification
The bench sweeps the step through every table entry in direct mode. It then pushes oversampled frames across each octave with fractional increment bits, so a sub-step that dropped or kept the wrong low bits would drift the phase and corrupt every later frame. Mode flips between oversampled and direct frames expose a design that keeps stale filter history (wrong first sample after the switch) or clears it every frame (wrong steady-state values under a recursive coefficient set). Saturating gains and a second strobe during a busy frame are aimed at missing clamps and at a sequencer that restarts or advances the phase twice.

// File: rtl/wto_pkg.sv
package wto_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_READ = 3'd1,
        ST_CAPT = 3'd2,
        ST_MAC  = 3'd3,
        ST_OCT  = 3'd4,
        ST_GAIN = 3'd5
    } wto_state_e;

    // register port regions (cfg_addr top two bits)
    localparam logic [1:0] RGN_TABLE = 2'd0;
    localparam logic [1:0] RGN_COEF  = 2'd1;
    localparam logic [1:0] RGN_THR   = 2'd2;
    localparam logic [1:0] RGN_OCTG  = 2'd3;

    // coefficient slots
    localparam int NUM_COEF = 5;
    localparam int CI_B0 = 0;
    localparam int CI_B1 = 1;
    localparam int CI_B2 = 2;
    localparam int CI_A1 = 3;
    localparam int CI_A2 = 4;

endpackage

// File: rtl/wto_table_ram.sv
module wto_table_ram #(
    parameter int AW = 10,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/wto_cfg_regs.sv
module wto_cfg_regs
    import wto_pkg::*;
#(
    parameter int AW     = 10,
    parameter int CW     = 16,
    parameter int OCT_N  = 10,
    parameter int OCT_IW = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [AW+1:0]         addr,
    input  logic [CW-1:0]         wdata,
    output logic                  tbl_we,
    output logic [AW-1:0]         tbl_waddr,
    output logic [NUM_COEF*CW-1:0] coef_flat,
    output logic [AW-1:0]         thresh,
    output logic [OCT_N*CW-1:0]   octg_flat
);
    localparam int CIDX_W = $clog2(NUM_COEF);
    localparam logic [CW-1:0] UNITY = CW'(1) << (CW - 2);

    typedef struct packed {
        logic [NUM_COEF-1:0][CW-1:0] coef;
        logic [AW-1:0]               thr;
        logic [OCT_N-1:0][CW-1:0]    octg;
    } cfg_t;

    cfg_t q, d;

    logic [1:0]        region;
    logic [CIDX_W-1:0] cidx;
    logic [OCT_IW-1:0] oidx;

    assign region = addr[AW+1:AW];
    assign cidx   = addr[CIDX_W-1:0];
    assign oidx   = addr[OCT_IW-1:0];

    always_comb begin
        d = q;
        if (we) begin
            case (region)
                RGN_COEF: if (int'(cidx) < NUM_COEF) d.coef[cidx] = wdata;
                RGN_THR:  d.thr = wdata[AW-1:0];
                RGN_OCTG: if (int'(oidx) < OCT_N) d.octg[oidx] = wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.coef        <= '0;
            q.coef[CI_B0] <= UNITY;
            q.thr         <= '1;
            for (int i = 0; i < OCT_N; i++) begin
                q.octg[i] <= UNITY;
            end
        end else begin
            q <= d;
        end
    end

    assign tbl_we    = we && (region == RGN_TABLE);
    assign tbl_waddr = addr[AW-1:0];
    assign coef_flat = q.coef;
    assign thresh    = q.thr;
    assign octg_flat = q.octg;

endmodule

// File: rtl/wto_mul.sv
module wto_mul #(
    parameter int AW = 16,
    parameter int BW = 16
) (
    input  logic signed [AW-1:0]    a,
    input  logic signed [BW-1:0]    b,
    output logic signed [AW+BW-1:0] p
);
    assign p = a * b;
endmodule

// File: rtl/aa_wavetable_osc.sv
module aa_wavetable_osc
    import wto_pkg::*;
#(
    parameter int PHASE_W  = 32,
    parameter int TABLE_AW = 10,
    parameter int SAMPLE_W = 16,
    parameter int COEF_W   = 16,
    parameter int OS_LOG2  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_strobe,
    input  logic [PHASE_W-1:0]  phase_inc,
    input  logic [COEF_W-1:0]   gain,
    input  logic                cfg_we,
    input  logic [TABLE_AW+1:0] cfg_addr,
    input  logic [COEF_W-1:0]   cfg_wdata,
    output logic [SAMPLE_W-1:0] out_sample,
    output logic                out_valid
);
    localparam int FRAC   = COEF_W - 2;
    localparam int PROD_W = SAMPLE_W + COEF_W;
    localparam int ACC_W  = PROD_W + 4;
    localparam int OCT_N  = TABLE_AW;
    localparam int OCT_IW = $clog2(OCT_N);
    localparam int NPT    = 1 << OS_LOG2;
    localparam int NMAC   = 2 * NUM_COEF;
    localparam int MAC_W  = $clog2(NMAC);
    localparam logic signed [ACC_W-1:0] ACC_HI = ACC_W'((64'sd1 <<< (SAMPLE_W - 1)) - 64'sd1);
    localparam logic signed [ACC_W-1:0] ACC_LO = -ACC_HI - ACC_W'(1);

    typedef struct packed {
        wto_state_e                 st;
        logic [PHASE_W-1:0]         phase;
        logic [PHASE_W-1:0]         inc;
        logic signed [COEF_W-1:0]   gn;
        logic [OCT_IW-1:0]          oct;
        logic                       mode;
        logic [OS_LOG2-1:0]         pt;
        logic [MAC_W-1:0]           mac;
        logic signed [SAMPLE_W-1:0] xc;
        logic signed [SAMPLE_W-1:0] x1;
        logic signed [SAMPLE_W-1:0] x2;
        logic signed [SAMPLE_W-1:0] mc;
        logic signed [SAMPLE_W-1:0] m1;
        logic signed [SAMPLE_W-1:0] m2;
        logic signed [SAMPLE_W-1:0] y1;
        logic signed [SAMPLE_W-1:0] y2;
        logic signed [SAMPLE_W-1:0] res;
        logic signed [SAMPLE_W-1:0] out;
        logic signed [ACC_W-1:0]    acc;
        logic                       valid;
    } osc_t;

    osc_t q, d;

    // configuration
    logic                       tbl_we;
    logic [TABLE_AW-1:0]        tbl_waddr;
    logic [NUM_COEF*COEF_W-1:0] coef_flat;
    logic [TABLE_AW-1:0]        thresh;
    logic [OCT_N*COEF_W-1:0]    octg_flat;
    logic [SAMPLE_W-1:0]        rdata;

    wto_cfg_regs #(
        .AW(TABLE_AW), .CW(COEF_W), .OCT_N(OCT_N), .OCT_IW(OCT_IW)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .coef_flat(coef_flat),
        .thresh(thresh), .octg_flat(octg_flat)
    );

    wto_table_ram #(.AW(TABLE_AW), .DW(SAMPLE_W)) u_tbl (
        .clk(clk), .we(tbl_we), .waddr(tbl_waddr), .wdata(cfg_wdata[SAMPLE_W-1:0]),
        .raddr(q.phase[PHASE_W-1 -: TABLE_AW]), .rdata(rdata)
    );

    logic signed [COEF_W-1:0] coef [NUM_COEF];
    logic signed [COEF_W-1:0] octg [OCT_N];

    for (genvar c = 0; c < NUM_COEF; c++) begin : g_coef
        assign coef[c] = coef_flat[c*COEF_W +: COEF_W];
    end
    for (genvar o = 0; o < OCT_N; o++) begin : g_octg
        assign octg[o] = octg_flat[o*COEF_W +: COEF_W];
    end

    // single shared multiplier
    logic signed [SAMPLE_W-1:0] mul_a;
    logic signed [COEF_W-1:0]   mul_b;
    logic signed [PROD_W-1:0]   prod;

    wto_mul #(.AW(SAMPLE_W), .BW(COEF_W)) u_mul (.a(mul_a), .b(mul_b), .p(prod));

    function automatic logic signed [SAMPLE_W-1:0] sat_s(input logic signed [ACC_W-1:0] v);
        if (v > ACC_HI) return ACC_HI[SAMPLE_W-1:0];
        if (v < ACC_LO) return ACC_LO[SAMPLE_W-1:0];
        return v[SAMPLE_W-1:0];
    endfunction

    function automatic logic [OCT_IW-1:0] top_bit(input logic [TABLE_AW-1:0] v);
        logic [OCT_IW-1:0] r;
        r = '0;
        for (int i = 0; i < TABLE_AW; i++) begin
            if (v[i]) r = OCT_IW'(i);
        end
        return r;
    endfunction

    logic [TABLE_AW-1:0]        step_in;
    logic                       os_sel;
    logic                       mul_neg;
    logic signed [ACC_W-1:0]    prod_ext;
    logic signed [ACC_W-1:0]    acc_next;
    logic signed [SAMPLE_W-1:0] ycur;

    assign step_in  = phase_inc[PHASE_W-1 -: TABLE_AW];
    assign os_sel   = step_in > thresh;
    assign prod_ext = ACC_W'(prod);

    always_comb begin
        d        = q;
        d.valid  = 1'b0;
        mul_a    = '0;
        mul_b    = '0;
        mul_neg  = 1'b0;
        acc_next = '0;
        ycur     = '0;
        case (q.st)
            ST_IDLE: begin
                if (frame_strobe) begin
                    d.inc  = phase_inc;
                    d.gn   = gain;
                    d.oct  = top_bit(step_in);
                    d.mode = os_sel;
                    d.pt   = '0;
                    d.mac  = '0;
                    d.acc  = '0;
                    if (os_sel != q.mode) begin
                        d.x1 = '0; d.x2 = '0;
                        d.m1 = '0; d.m2 = '0;
                        d.y1 = '0; d.y2 = '0;
                    end
                    d.st = ST_READ;
                end
            end
            ST_READ: d.st = ST_CAPT;
            ST_CAPT: begin
                d.xc = rdata;
                if (q.mode) begin
                    d.st = ST_MAC;
                end else begin
                    d.res   = rdata;
                    d.phase = q.phase + q.inc;
                    d.st    = ST_GAIN;
                end
            end
            ST_MAC: begin
                case (int'(q.mac))
                    0: begin mul_a = q.xc; mul_b = coef[CI_B0]; end
                    1: begin mul_a = q.x1; mul_b = coef[CI_B1]; end
                    2: begin mul_a = q.x2; mul_b = coef[CI_B2]; end
                    3: begin mul_a = q.m1; mul_b = coef[CI_A1]; mul_neg = 1'b1; end
                    4: begin mul_a = q.m2; mul_b = coef[CI_A2]; mul_neg = 1'b1; end
                    5: begin mul_a = q.mc; mul_b = coef[CI_B0]; end
                    6: begin mul_a = q.m1; mul_b = coef[CI_B1]; end
                    7: begin mul_a = q.m2; mul_b = coef[CI_B2]; end
                    8: begin mul_a = q.y1; mul_b = coef[CI_A1]; mul_neg = 1'b1; end
                    default: begin mul_a = q.y2; mul_b = coef[CI_A2]; mul_neg = 1'b1; end
                endcase
                acc_next = mul_neg ? (q.acc - prod_ext) : (q.acc + prod_ext);
                d.acc    = acc_next;
                d.mac    = q.mac + 1'b1;
                if (int'(q.mac) == NUM_COEF - 1) begin
                    d.mc  = sat_s(acc_next >>> FRAC);
                    d.acc = '0;
                end
                if (int'(q.mac) == NMAC - 1) begin
                    ycur    = sat_s(acc_next >>> FRAC);
                    d.acc   = '0;
                    d.mac   = '0;
                    d.x2    = q.x1; d.x1 = q.xc;
                    d.m2    = q.m1; d.m1 = q.mc;
                    d.y2    = q.y1; d.y1 = ycur;
                    d.phase = q.phase + (q.inc >> OS_LOG2);
                    d.pt    = q.pt + 1'b1;
                    if (int'(q.pt) == NPT - 1) begin
                        d.res = ycur;
                        d.st  = ST_OCT;
                    end else begin
                        d.st  = ST_READ;
                    end
                end
            end
            ST_OCT: begin
                mul_a = q.res;
                mul_b = octg[q.oct];
                d.res = sat_s(prod_ext >>> FRAC);
                d.st  = ST_GAIN;
            end
            ST_GAIN: begin
                mul_a   = q.res;
                mul_b   = q.gn;
                d.out   = sat_s(prod_ext >>> FRAC);
                d.valid = 1'b1;
                d.st    = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign out_sample = q.out;
    assign out_valid  = q.valid;

    // observation points for the bound checker
    logic               busy;
    logic [PHASE_W-1:0] phase_now;
    assign busy      = (q.st != ST_IDLE);
    assign phase_now = q.phase;

endmodule

// File: rtl/aa_wavetable_osc_chk.sv
module aa_wavetable_osc_chk #(
    parameter int PHASE_W  = 32,
    parameter int SAMPLE_W = 16,
    parameter int OS_LOG2  = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                frame_strobe,
    input logic                out_valid,
    input logic [SAMPLE_W-1:0] out_sample,
    input logic                busy,
    input logic [PHASE_W-1:0]  phase_now
);
    localparam int LAT_MAX = 8 + (1 << OS_LOG2) * 12;

    logic        pend_q;
    logic [15:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            cnt_q  <= '0;
        end else if (frame_strobe && !busy) begin
            pend_q <= 1'b1;
            cnt_q  <= '0;
        end else if (out_valid) begin
            pend_q <= 1'b0;
            cnt_q  <= '0;
        end else if (pend_q) begin
            cnt_q  <= cnt_q + 16'd1;
        end
    end

    // R9
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_sample));

    // R9
    latency_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> (int'(cnt_q) <= LAT_MAX));

    // R10
    valid_needs_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (pend_q && !busy));

    // R3
    phase_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !frame_strobe) |=> $stable(phase_now));

endmodule

bind aa_wavetable_osc aa_wavetable_osc_chk #(
    .PHASE_W(PHASE_W), .SAMPLE_W(SAMPLE_W), .OS_LOG2(OS_LOG2)
) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe), .out_valid(out_valid),
    .out_sample(out_sample), .busy(busy), .phase_now(phase_now)
);

// File: tb/aa_wavetable_osc_test.sv
module aa_wavetable_osc_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_strobe = 1'b0;
    logic [31:0] phase_inc = '0;
    logic [15:0] gain = '0;
    logic        cfg_we = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] out_sample;
    logic        out_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    aa_wavetable_osc uut (
        .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe), .phase_inc(phase_inc),
        .gain(gain), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .out_sample(out_sample), .out_valid(out_valid)
    );

    // ---------------- reference model state ----------------
    int          tbl [1024];
    int          cf [5];
    int          thr;
    int          og [10];
    logic [31:0] mph;
    bit          mmode;
    longint      sx1, sx2, sm1, sm2, sy1, sy2;

    function automatic longint sat16(longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic int tval(int i);
        int v;
        v = (i * i * 13 + i * 517 + 91) % 65536;
        return v - 32768;
    endfunction

    function automatic longint model_frame(logic [31:0] inc, int g);
        logic [9:0]  step;
        logic [31:0] sub;
        bit          os;
        longint      r, x, m, y;
        int          k;
        step = inc[31:22];
        os = (int'(step) > thr);
        if (os != mmode) begin
            sx1 = 0; sx2 = 0; sm1 = 0; sm2 = 0; sy1 = 0; sy2 = 0;
        end
        mmode = os;
        r = 0;
        if (!os) begin
            r = tbl[mph[31:22]];
            mph = mph + inc;
        end else begin
            sub = inc >> 4;
            for (int j = 0; j < 16; j++) begin
                x = tbl[mph[31:22]];
                m = sat16((cf[0]*x + cf[1]*sx1 + cf[2]*sx2 - cf[3]*sm1 - cf[4]*sm2) >>> 14);
                y = sat16((cf[0]*m + cf[1]*sm1 + cf[2]*sm2 - cf[3]*sy1 - cf[4]*sy2) >>> 14);
                sx2 = sx1; sx1 = x;
                sm2 = sm1; sm1 = m;
                sy2 = sy1; sy1 = y;
                r = y;
                mph = mph + sub;
            end
            k = 0;
            for (int b = 0; b < 10; b++) if (step[b]) k = b;
            r = sat16((r * og[k]) >>> 14);
        end
        return sat16((r * g) >>> 14);
    endfunction

    // ---------------- helpers ----------------
    task automatic check(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cfg_wr(logic [1:0] rgn, int idx, int data);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = {rgn, 10'(idx)};
        cfg_wdata = 16'(data);
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic set_coefs(int b0, int b1, int b2, int a1, int a2);
        cf[0] = b0; cf[1] = b1; cf[2] = b2; cf[3] = a1; cf[4] = a2;
        for (int i = 0; i < 5; i++) cfg_wr(2'd1, i, cf[i]);
    endtask

    // drives one strobe, waits for the pulse, compares; optional timing checks
    task automatic run_frame(logic [31:0] inc, int g, string tag, bit timing);
        longint exp, act;
        int     lat;
        bit     got;
        exp = model_frame(inc, g);
        @(negedge clk);
        phase_inc = inc; gain = 16'(g); frame_strobe = 1'b1;
        @(negedge clk);
        frame_strobe = 1'b0;
        lat = 1; got = 0;
        while (!got && lat < 400) begin
            if (out_valid) got = 1;
            else begin @(negedge clk); lat++; end
        end
        act = longint'($signed(out_sample));
        check(got && act == exp, tag, act, exp);
        if (timing) begin
            check(lat <= 200, "R9 latency", lat, 200);
            @(negedge clk);
            check(!out_valid, "R9 pulse width", out_valid, 0);
            repeat (5) @(negedge clk);
            check(longint'($signed(out_sample)) == exp, "R9 hold", $signed(out_sample), exp);
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        int     vcount;
        longint e1;
        cf[0] = 16384; cf[1] = 0; cf[2] = 0; cf[3] = 0; cf[4] = 0;
        thr = 1023;
        for (int i = 0; i < 10; i++) og[i] = 16384;
        mph = '0; mmode = 0;
        sx1 = 0; sx2 = 0; sm1 = 0; sm2 = 0; sy1 = 0; sy2 = 0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 valid after reset", out_valid, 0);
        check(out_sample == 16'd0, "R1 sample after reset", out_sample, 0);

        // R2: load the whole table through region 0
        for (int i = 0; i < 1024; i++) begin
            tbl[i] = tval(i);
            cfg_wr(2'd0, i, tbl[i]);
        end

        // R1: default threshold keeps even the largest step in direct mode
        run_frame({10'd1023, 22'h12345}, 16384, "R1 default threshold direct", 1'b0);
        run_frame({10'd700, 22'h0}, 16384, "R1 default threshold direct", 1'b0);

        // R2/R3: exhaustive direct sweep, step 1 walks every table entry
        for (int i = 0; i < 1024; i++) begin
            run_frame(32'h0040_0000, 16384, "R2 R3 table sweep", 1'b0);
        end

        // R3: gains including saturation and negative values
        for (int i = 0; i < 24; i++) begin
            int gs [6] = '{32767, -32768, 8192, -16384, 24000, 1};
            run_frame(32'(i * 40503 + 32'h0123_4567) & 32'h3FFF_FFFF, gs[i % 6], "R3 direct gain", 1'b0);
        end

        // R1: threshold lowered, default passthrough filter and unity octave gains
        thr = 8;
        cfg_wr(2'd2, 0, thr);
        run_frame({10'd9, 22'h2AAAA}, 16384, "R1 default coefs octave gains", 1'b1);

        // R4: boundary, step equal to threshold is direct, one above is oversampled
        run_frame({10'd8, 22'h1F}, 16384, "R4 step equal threshold", 1'b0);
        run_frame({10'd9, 22'h1F}, 16384, "R4 step above threshold", 1'b0);

        // R5: passthrough filter, oversampled points with fractional sub-steps
        for (int s = 9; s < 1024; s += 37) begin
            run_frame({10'(s), 22'(s * 12345)}, 16384, "R5 oversample points", 1'b0);
        end

        // R8: distinct octave gains
        for (int i = 0; i < 10; i++) begin
            og[i] = 16384 - i * 1500;
            cfg_wr(2'd3, i, og[i]);
        end
        for (int s = 9; s < 1024; s += 53) begin
            run_frame({10'(s), 22'(s * 777)}, 20000, "R8 octave gain", 1'b0);
        end

        // R6: recursive low-pass coefficients, history kept across frames (R7)
        set_coefs(1024, 2048, 1024, -19661, 7373);
        for (int s = 9; s < 1024; s += 41) begin
            run_frame({10'(s), 22'(s * 9091)}, 16384, "R6 R7 biquad cascade", 1'b0);
        end
        for (int i = 0; i < 6; i++) begin
            run_frame({10'd12, 22'h155555}, 16384, "R6 R7 steady tone", 1'b0);
        end

        // R6: aggressive coefficients to drive section saturation
        set_coefs(30000, 30000, 30000, -30000, 16000);
        for (int i = 0; i < 6; i++) begin
            run_frame({10'(40 + i * 90), 22'h0ABCD}, 16384, "R6 section saturation", 1'b0);
        end

        // R7: mode flips clear the history
        set_coefs(1024, 2048, 1024, -19661, 7373);
        run_frame({10'd300, 22'h3}, 16384, "R7 os frame", 1'b0);
        run_frame({10'd3, 22'h5}, 16384, "R7 switch to direct", 1'b0);
        run_frame({10'd300, 22'h3}, 16384, "R7 os after clear", 1'b0);
        run_frame({10'd301, 22'h7}, 16384, "R7 os keeps history", 1'b0);
        run_frame({10'd2, 22'h9}, -12000, "R7 switch to direct", 1'b0);
        run_frame({10'd77, 22'h11}, 16384, "R7 os after clear", 1'b1);

        // R10: second strobe while busy is ignored
        e1 = model_frame({10'd500, 22'h2468}, 16384);
        @(negedge clk);
        phase_inc = {10'd500, 22'h2468}; gain = 16'd16384; frame_strobe = 1'b1;
        @(negedge clk);
        frame_strobe = 1'b0;
        repeat (4) @(negedge clk);
        phase_inc = {10'd20, 22'h0}; frame_strobe = 1'b1;
        @(negedge clk);
        frame_strobe = 1'b0;
        vcount = 0;
        for (int c = 0; c < 300; c++) begin
            if (out_valid) begin
                vcount++;
                check(longint'($signed(out_sample)) == e1, "R10 busy frame result", $signed(out_sample), e1);
            end
            @(negedge clk);
        end
        check(vcount == 1, "R10 one pulse", vcount, 1);
        run_frame({10'd500, 22'h2468}, 16384, "R10 phase advanced once", 1'b0);
        run_frame({10'd4, 22'h0}, 16384, "R10 phase advanced once", 1'b1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule